// File: doc/BRIEF.md
# Buffered Output-Compare Timer Channel

This block is a single timer channel. A free-running up-counter advances on every cycle in which a count enable is high. On each such cycle the counter is tested for equality against a compare register. A match can drive an output pin low, drive it high or toggle it, as a 4-bit output-control code selects. Each code also fixes the pin's starting level, which is applied as soon as the code is written.

With buffering switched on, every compare match loads a shadow (buffer) register into the compare register. Software can therefore prepare the next compare value at any time, and a period or duty change takes effect only at a match boundary.

Registers are written through a two-state write cycle, T1 then T2. A match that falls in the T2 state of a buffer write copies the buffer's old content. A match sets a flag. Software clears the flag by writing a zero to it, and the flag drives an interrupt request when the request is enabled.

Top module: `cmpch_top`

## Requirements
- R1: The counter starts at 0 after reset. It adds one on every clock edge at which `cnt_en` is high, wraps from 2^CNT_W-1 to 0, and holds otherwise.
- R2: Output-control codes 0000 (reset value), 0100 and every code with bit 3 set disable the output. `pin_oe` is then low and `pin_out` keeps its value through compare matches.
- R3: Codes 0001, 0010 and 0011 set `pin_out` to 0 at the edge where the code is written. Each later compare match then drives the pin to 0 (0001), drives it to 1 (0010) or toggles it (0011).
- R4: Codes 0101, 0110 and 0111 set `pin_out` to 1 at the edge where the code is written. Each later compare match then drives the pin to 0 (0101), drives it to 1 (0110) or toggles it (0111).
- R5: A compare match is a cycle with `cnt_en` high and `count` equal to `cmp_val`. The match flag is set at the end of that cycle.
- R6: When the buffer-enable bit is set, a compare match loads `buf_val` into `cmp_val` at the same edge.
- R7: If a compare match falls in the T2 state of a buffer write, the compare register receives the buffer content from before the write. The buffer still takes the new value at the end of T2.
- R8: A write starts with a one-cycle `wr_start` pulse (T1), which captures `wr_addr` and `wr_data`. The next cycle is T2, and the addressed register takes the data at the end of T2. A `wr_start` during T2 is ignored. Address map:
  - 0: compare
  - 1: buffer
  - 2: control (bits [3:0] code, bit 4 buffer enable, bit 5 interrupt enable)
  - 3: flag
- R9: A flag write with data bit 0 equal to 0 clears the flag. If a compare match occurs at the same edge, the flag stays set.
- R10: `irq` is high exactly when the flag and the interrupt-enable bit are both set.
- R11: A compare-register write whose T2 coincides with a buffered match loads the written value, not the buffer content.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counter increment enable |
| wr_start | input | 1 | Starts a write cycle (T1) |
| wr_addr | input | 2 | Register select |
| wr_data | input | CNT_W | Write data |
| count | output | CNT_W | Counter value |
| cmp_val | output | CNT_W | Compare register |
| buf_val | output | CNT_W | Buffer register |
| pin_out | output | 1 | Compare output level |
| pin_oe | output | 1 | Compare output enabled |
| flag | output | 1 | Match flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the channel with CNT_W = 8, which shrinks a full counter period to 256 cycles. At that width, wraparound, repeated matches under every output code, and the exact match timing needed for T2 collisions are all reached in a short run. A behavioural model is compared against the outputs every cycle. Directed sequences place buffer, compare and flag writes so that their T2 lands on the match cycle. A random phase then mixes writes and count gaps.

// File: rtl/cmpch_pkg.sv
package cmpch_pkg;
  typedef enum logic [1:0] {
    SEL_CMP = 2'd0,
    SEL_BUF = 2'd1,
    SEL_CTL = 2'd2,
    SEL_FLG = 2'd3
  } reg_sel_e;

  localparam int CODE_W   = 4;
  localparam int BUFEN_BIT = 4;
  localparam int IRQEN_BIT = 5;

  function automatic logic code_drives(input logic [CODE_W-1:0] c);
    return !c[3] && (c[1:0] != 2'b00);
  endfunction
endpackage

// File: rtl/cmpch_wrseq.sv
module cmpch_wrseq
  import cmpch_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_start,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              commit,
  output reg_sel_e          commit_sel,
  output logic [DATA_W-1:0] commit_data
);
  logic              in_t2_q;
  reg_sel_e          sel_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_t2_q <= 1'b0;
      sel_q   <= SEL_CMP;
      data_q  <= '0;
    end else if (in_t2_q) begin
      in_t2_q <= 1'b0;
    end else if (wr_start) begin
      in_t2_q <= 1'b1;
      sel_q   <= reg_sel_e'(wr_addr);
      data_q  <= wr_data;
    end
  end

  assign commit      = in_t2_q;
  assign commit_sel  = sel_q;
  assign commit_data = data_q;
endmodule

// File: rtl/cmpch_counter.sv
module cmpch_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] count,
  output logic             match
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_q + 1'b1;
  end

  assign count = cnt_q;
  assign match = cnt_en && (cnt_q == cmp_val);
endmodule

// File: rtl/cmpch_outctl.sv
module cmpch_outctl
  import cmpch_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              code_load,
  input  logic [CODE_W-1:0] code_new,
  input  logic              match,
  output logic              pin_out,
  output logic              pin_oe
);
  logic [CODE_W-1:0] code_q;
  logic              pin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      pin_q  <= 1'b0;
    end else if (code_load) begin
      code_q <= code_new;
      if (code_drives(code_new)) pin_q <= code_new[2];
    end else if (match && code_drives(code_q)) begin
      case (code_q[1:0])
        2'b01:   pin_q <= 1'b0;
        2'b10:   pin_q <= 1'b1;
        2'b11:   pin_q <= ~pin_q;
        default: pin_q <= pin_q;
      endcase
    end
  end

  assign pin_out = pin_q;
  assign pin_oe  = code_drives(code_q);
endmodule

// File: rtl/cmpch_top.sv
module cmpch_top
  import cmpch_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             wr_start,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] buf_val,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             flag,
  output logic             irq
);
  localparam int MIN_W = IRQEN_BIT + 1;

  logic             commit;
  reg_sel_e         commit_sel;
  logic [CNT_W-1:0] commit_data;
  logic             match;
  logic [CNT_W-1:0] cmp_q, buf_q;
  logic             buf_en_q, irq_en_q, flag_q;
  logic             ctl_wr;

  initial begin
    if (CNT_W < MIN_W) $error("CNT_W too small for control fields");
  end

  cmpch_wrseq #(.DATA_W(CNT_W)) u_wrseq (
    .clk(clk), .rst(rst), .wr_start(wr_start), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit(commit), .commit_sel(commit_sel),
    .commit_data(commit_data)
  );

  cmpch_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .cmp_val(cmp_q),
    .count(count), .match(match)
  );

  assign ctl_wr = commit && (commit_sel == SEL_CTL);

  cmpch_outctl u_outctl (
    .clk(clk), .rst(rst), .code_load(ctl_wr),
    .code_new(commit_data[CODE_W-1:0]), .match(match),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q    <= '0;
      buf_q    <= '0;
      buf_en_q <= 1'b0;
      irq_en_q <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      if (commit && commit_sel == SEL_CMP) cmp_q <= commit_data;
      else if (match && buf_en_q)          cmp_q <= buf_q;

      if (commit && commit_sel == SEL_BUF) buf_q <= commit_data;

      if (ctl_wr) begin
        buf_en_q <= commit_data[BUFEN_BIT];
        irq_en_q <= commit_data[IRQEN_BIT];
      end

      if (match) flag_q <= 1'b1;
      else if (commit && commit_sel == SEL_FLG && !commit_data[0]) flag_q <= 1'b0;
    end
  end

  assign cmp_val = cmp_q;
  assign buf_val = buf_q;
  assign flag    = flag_q;
  assign irq     = flag_q && irq_en_q;
endmodule

// File: rtl/cmpch_chk.sv
module cmpch_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_en,
  input logic             wr_start,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] cmp_val,
  input logic [CNT_W-1:0] buf_val,
  input logic             pin_out,
  input logic             pin_oe,
  input logic             flag,
  input logic             irq,
  input logic             buf_en,
  input logic             commit,
  input logic [1:0]       commit_sel,
  input logic [CNT_W-1:0] commit_data
);
  assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
    cnt_en |=> count == CNT_W'($past(count) + 1'b1));

  assert_pin_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!pin_oe && !$past(wr_start)) |=> $stable(pin_out));

  assert_flag_set_R5: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && count == cmp_val) |=> flag);

  assert_buf_copy_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && count == cmp_val && buf_en && !(commit && commit_sel == 2'd0))
    |=> cmp_val == $past(buf_val));

  assert_t2_collide_R7: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && count == cmp_val && buf_en && commit && commit_sel == 2'd1)
    |=> (cmp_val == $past(buf_val) && buf_val == $past(commit_data)));

  assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag);

  assert_cmp_write_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (commit && commit_sel == 2'd0) |=> cmp_val == $past(commit_data));
endmodule

bind cmpch_top cmpch_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cnt_en(cnt_en), .wr_start(wr_start),
  .count(count), .cmp_val(cmp_val), .buf_val(buf_val),
  .pin_out(pin_out), .pin_oe(pin_oe), .flag(flag), .irq(irq),
  .buf_en(buf_en_q), .commit(commit), .commit_sel(commit_sel),
  .commit_data(commit_data)
);

// File: tb/test_cmpch_top.sv
module test_cmpch_top;
  localparam int W = 8;
  localparam int MOD = 1 << W;

  logic clk = 1'b0, rst = 1'b1, cnt_en = 1'b0, wr_start = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] count, cmp_val, buf_val;
  logic pin_out, pin_oe, flag, irq;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  cmpch_top #(.CNT_W(W)) i_cmpch_top (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .wr_start(wr_start),
    .wr_addr(wr_addr), .wr_data(wr_data), .count(count),
    .cmp_val(cmp_val), .buf_val(buf_val), .pin_out(pin_out),
    .pin_oe(pin_oe), .flag(flag), .irq(irq)
  );

  // behavioural reference model
  int m_cnt, m_cmp, m_buf, m_code, m_pin, m_flag, m_bufen, m_ie;
  int m_t2, m_waddr, m_wdata;
  bit model_on = 0;

  function automatic bit drives(int c);
    return (c < 8) && ((c % 4) != 0);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_cmp = 0; m_buf = 0; m_code = 0; m_pin = 0;
      m_flag = 0; m_bufen = 0; m_ie = 0; m_t2 = 0; m_waddr = 0; m_wdata = 0;
      model_on = 1;
    end else begin
      bit mt, cw;
      int old_buf;
      mt = cnt_en && (m_cnt == m_cmp);
      cw = m_t2 == 1;
      old_buf = m_buf;
      if (cw && m_waddr == 0) m_cmp = m_wdata;
      else if (mt && m_bufen == 1) m_cmp = old_buf;
      if (cw && m_waddr == 1) m_buf = m_wdata;
      if (cw && m_waddr == 2) begin
        m_code = m_wdata % 16;
        m_bufen = (m_wdata / 16) % 2;
        m_ie = (m_wdata / 32) % 2;
        if (drives(m_code)) m_pin = (m_code / 4) % 2;
      end else if (mt && drives(m_code)) begin
        if (m_code % 4 == 1) m_pin = 0;
        else if (m_code % 4 == 2) m_pin = 1;
        else m_pin = 1 - m_pin;
      end
      if (mt) m_flag = 1;
      else if (cw && m_waddr == 3 && (m_wdata % 2) == 0) m_flag = 0;
      if (cnt_en) m_cnt = (m_cnt + 1) % MOD;
      if (m_t2 == 1) m_t2 = 0;
      else if (wr_start) begin
        m_t2 = 1; m_waddr = wr_addr; m_wdata = wr_data;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_on && !rst) begin
      chk("R1 count", count, m_cnt);
      chk("R2 pin_oe", pin_oe, drives(m_code));
      chk("R3 pin_out", pin_out, m_pin);
      chk("R6 cmp_val", cmp_val, m_cmp);
      chk("R8 buf_val", buf_val, m_buf);
      chk("R5 flag", flag, m_flag);
      chk("R10 irq", irq, m_flag && m_ie);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input int a, input int d);
    wr_start = 1; wr_addr = a[1:0]; wr_data = d[W-1:0];
    step();
    wr_start = 0;
    step();
  endtask

  task automatic to_match();
    while (!(cnt_en && m_cnt == m_cmp)) step();
    step();
  endtask

  task automatic align_t2();
    while (m_cnt != (m_cmp + MOD - 1) % MOD) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ob;
    repeat (3) step();
    rst = 0;
    #1;
    // reset state
    chk("R1 reset count", count, 0);
    chk("R2 reset pin_oe", pin_oe, 0);
    chk("R5 reset flag", flag, 0);
    chk("R10 reset irq", irq, 0);

    // R3: toggle code with irq enable
    wr(0, 10);
    chk("R8 cmp write", cmp_val, 10);
    wr(2, 'h23);
    chk("R3 initial 0", pin_out, 0);
    chk("R2 oe on", pin_oe, 1);
    cnt_en = 1;
    to_match();
    chk("R3 toggle", pin_out, 1);
    chk("R5 flag set", flag, 1);
    chk("R10 irq", irq, 1);
    wr(3, 0);
    chk("R9 flag clear", flag, 0);

    // R4 codes 0101..0111 and R3 codes 0001, 0010
    for (int c = 1; c < 8; c++) begin
      if (c == 4) continue;
      wr(2, c);
      chk(c > 4 ? "R4 initial" : "R3 initial", pin_out, (c / 4) % 2);
      to_match();
      chk(c > 4 ? "R4 match" : "R3 match", pin_out,
          (c % 4 == 1) ? 0 : (c % 4 == 2) ? 1 : 1 - (c / 4) % 2);
    end

    // R2 disabled codes hold the pin
    wr(2, 'h3);
    to_match();
    ob = pin_out;
    wr(2, 'h4);
    chk("R2 disable oe", pin_oe, 0);
    to_match();
    chk("R2 pin held", pin_out, ob);
    wr(2, 'h9);
    to_match();
    chk("R2 code 1001 held", pin_out, ob);

    // R6 buffer transfer
    wr(1, 50);
    wr(2, 'h13);
    to_match();
    chk("R6 buffer copy", cmp_val, 50);

    // R7 buffer write with T2 on a match
    wr(1, 90);
    align_t2();
    wr(1, 120);
    chk("R7 old buffer used", cmp_val, 90);
    chk("R7 new buffer kept", buf_val, 120);

    // R11 compare write with T2 on a buffered match
    align_t2();
    wr(0, 33);
    chk("R11 write wins", cmp_val, 33);

    // R9 match beats flag clear
    align_t2();
    wr(3, 0);
    chk("R9 set wins", flag, 1);
    wr(3, 0);
    chk("R9 cleared", flag, 0);

    // R8 wr_start during T2 ignored
    wr_start = 1; wr_addr = 2'd1; wr_data = 8'd7;
    step();
    wr_addr = 2'd0; wr_data = 8'd200;
    step();
    wr_start = 0;
    step();
    chk("R8 buffer written", buf_val, 7);
    chk("R8 second start ignored", cmp_val == 200, 0);

    // R1 wraparound
    wr(2, 0);
    while (m_cnt != MOD - 1) step();
    step();
    chk("R1 wrap", count, 0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      cnt_en = ($urandom % 8) != 0;
      if (!m_t2 && ($urandom % 6) == 0) begin
        int a;
        a = $urandom % 4;
        wr_start = 1; wr_addr = a[1:0];
        wr_data = (a == 2) ? W'($urandom % 64) : W'($urandom);
      end else wr_start = 0;
      step();
    end
    wr_start = 0;
    step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule